// File: doc/BRIEF.md
# Duplex Lockstep Match Checker

This block watches two identical processors that run in lockstep from one shared clock. One of them drives the system as the active unit. The other repeats the same work and serves only as a checker. Each processor has its own copy of the bus, so each one presents a full bundle every cycle: an address, write data, a read strobe and a write strobe. The checker compares the two bundles in the same clock cycle. When they differ, it raises a fault interrupt to the fault-handling logic. It does not stop either processor.

The interrupt stays pending until it is acknowledged. A capture pair keeps the first two disagreeing bundles seen since the last acknowledge, for later analysis. A saturating counter keeps a running total of disagreeing cycles. The block also holds the active-unit selection. A switchover request hands control to the standby unit, but only while a fault is pending. Deciding which unit is actually faulty is left to the software that services the interrupt.

Top module: `duplex_match_chk`

## Requirements
- R1: After reset, `active_unit` is 0, `fault_irq` is 0, `miss_count` is 0, and both capture outputs are 0.
- R2: A cycle is compared only when `cmp_en` is 1 and at least one of the four strobes (either unit's read or write strobe) is 1. In any other cycle, differing bundles raise no fault and leave the counter unchanged.
- R3: In a compared cycle, a difference in any field (address, write data, read strobe or write strobe) sets `fault_irq` at that clock edge, so it reads 1 in the following cycle.
- R4: Once set, `fault_irq` stays at 1 until an `irq_ack` or an honoured switchover clears it at a clock edge.
- R5: `miss_count` rises by one for each compared cycle with a difference, stops at 2^CNT_W-1, and is cleared only by reset.
- R6: When a difference is found and no fault is pending, `cap_u0` and `cap_u1` load the two bundles. Each is packed as {write strobe, read strobe, address, write data}, with the write data in the low DATA_W bits.
- R7: A difference found while a fault is pending, with no clear in that cycle, leaves both capture outputs unchanged.
- R8: A `swap_req` while a fault is pending toggles `active_unit` and clears `fault_irq` at the same clock edge.
- R9: A `swap_req` while no fault is pending has no effect on `active_unit`.
- R10: If a difference and a clear (ack or honoured swap) fall in the same cycle, the fault stays pending and the capture outputs take the new pair.
- R11: Identical bundles in compared cycles never raise a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared lockstep clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_en | input | 1 | Allows comparison in this cycle |
| u0_addr | input | ADDR_W | Unit 0 bus address |
| u0_wdata | input | DATA_W | Unit 0 write data |
| u0_rd_stb | input | 1 | Unit 0 read strobe |
| u0_wr_stb | input | 1 | Unit 0 write strobe |
| u1_addr | input | ADDR_W | Unit 1 bus address |
| u1_wdata | input | DATA_W | Unit 1 write data |
| u1_rd_stb | input | 1 | Unit 1 read strobe |
| u1_wr_stb | input | 1 | Unit 1 write strobe |
| irq_ack | input | 1 | Clears the pending fault |
| swap_req | input | 1 | Requests that the standby unit become active |
| fault_irq | output | 1 | Fault interrupt, level, held until cleared |
| active_unit | output | 1 | Index of the active unit |
| miss_count | output | CNT_W | Saturating count of disagreeing cycles |
| cap_u0 | output | ADDR_W+DATA_W+2 | Captured unit 0 bundle |
| cap_u1 | output | ADDR_W+DATA_W+2 | Captured unit 1 bundle |

## Verification
The properties assume that `irq_ack` and `swap_req` are plain single-cycle levels sampled at the clock. They also assume that both bundles are stable around each edge, as two lockstep units on one clock would be. Every stimulus is applied on the falling edge and held for a whole cycle. Mismatch, acknowledge and switchover are raised together only in the scenario built to test their priority, and every scenario starts from a cleared fault. Because the hold properties require ack and swap to be low, they are not checked in the cycle where a clear takes place.

// File: rtl/dlc_pkg.sv
`timescale 1ns/1ps
package dlc_pkg;
  typedef enum logic {UNIT0 = 1'b0, UNIT1 = 1'b1} unit_e;

  typedef struct packed {
    logic wr;
    logic rd;
  } strobe_t;
endpackage

// File: rtl/dlc_bundle_cmp.sv
`timescale 1ns/1ps
module dlc_bundle_cmp #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int BUS_W = ADDR_W + DATA_W + 2
) (
  input  logic             cmp_en,
  input  logic [BUS_W-1:0] a_bus,
  input  logic [BUS_W-1:0] b_bus,
  output logic             miss
);
  import dlc_pkg::*;

  strobe_t     a_stb;
  strobe_t     b_stb;
  logic        qualified;
  logic [BUS_W-1:0] bit_diff;

  assign a_stb = a_bus[BUS_W-1 -: 2];
  assign b_stb = b_bus[BUS_W-1 -: 2];
  assign qualified = cmp_en & (a_stb.rd | a_stb.wr | b_stb.rd | b_stb.wr);

  for (genvar i = 0; i < BUS_W; i++) begin : g_lane
    assign bit_diff[i] = a_bus[i] ^ b_bus[i];
  end

  assign miss = qualified & (|bit_diff);
endmodule

// File: rtl/dlc_fault_log.sv
`timescale 1ns/1ps
module dlc_fault_log #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  localparam int BUS_W = ADDR_W + DATA_W + 2,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss,
  input  logic             clr,
  input  logic [BUS_W-1:0] a_bus,
  input  logic [BUS_W-1:0] b_bus,
  output logic             pending,
  output logic [CNT_W-1:0] count,
  output logic [BUS_W-1:0] cap_a,
  output logic [BUS_W-1:0] cap_b
);
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             cap_en;
  logic [BUS_W-1:0] cap_a_q, cap_b_q;

  always_comb begin
    pend_d = pend_q;
    if (clr)  pend_d = 1'b0;
    if (miss) pend_d = 1'b1;
    cnt_en = miss && (cnt_q != CNT_MAX);
    cnt_d  = cnt_q + 1'b1;
    cap_en = miss && (!pend_q || clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a_q <= '0;
      cap_b_q <= '0;
    end else if (cap_en) begin
      cap_a_q <= a_bus;
      cap_b_q <= b_bus;
    end
  end

  assign pending = pend_q;
  assign count   = cnt_q;
  assign cap_a   = cap_a_q;
  assign cap_b   = cap_b_q;
endmodule

// File: rtl/dlc_role_ctl.sv
`timescale 1ns/1ps
module dlc_role_ctl (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           swap_req,
  input  logic           pending,
  output logic           swap_go,
  output dlc_pkg::unit_e active
);
  import dlc_pkg::*;

  unit_e act_q, act_d;

  always_comb begin
    swap_go = swap_req & pending;
    act_d   = (act_q == UNIT0) ? UNIT1 : UNIT0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= UNIT0;
    end else if (swap_go) begin
      act_q <= act_d;
    end
  end

  assign active = act_q;
endmodule

// File: rtl/duplex_match_chk.sv
`timescale 1ns/1ps
module duplex_match_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  localparam int BUS_W = ADDR_W + DATA_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_en,
  input  logic [ADDR_W-1:0] u0_addr,
  input  logic [DATA_W-1:0] u0_wdata,
  input  logic              u0_rd_stb,
  input  logic              u0_wr_stb,
  input  logic [ADDR_W-1:0] u1_addr,
  input  logic [DATA_W-1:0] u1_wdata,
  input  logic              u1_rd_stb,
  input  logic              u1_wr_stb,
  input  logic              irq_ack,
  input  logic              swap_req,
  output logic              fault_irq,
  output logic              active_unit,
  output logic [CNT_W-1:0]  miss_count,
  output logic [BUS_W-1:0]  cap_u0,
  output logic [BUS_W-1:0]  cap_u1
);
  import dlc_pkg::*;

  logic [BUS_W-1:0] bus0, bus1;
  logic             miss;
  logic             pending;
  logic             swap_go;
  logic             clr;
  unit_e            active;

  assign bus0 = {u0_wr_stb, u0_rd_stb, u0_addr, u0_wdata};
  assign bus1 = {u1_wr_stb, u1_rd_stb, u1_addr, u1_wdata};
  assign clr  = irq_ack | swap_go;

  dlc_bundle_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) cmp_i (
    .cmp_en (cmp_en),
    .a_bus  (bus0),
    .b_bus  (bus1),
    .miss   (miss)
  );

  dlc_fault_log #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) log_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .miss    (miss),
    .clr     (clr),
    .a_bus   (bus0),
    .b_bus   (bus1),
    .pending (pending),
    .count   (miss_count),
    .cap_a   (cap_u0),
    .cap_b   (cap_u1)
  );

  dlc_role_ctl role_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .swap_req (swap_req),
    .pending  (pending),
    .swap_go  (swap_go),
    .active   (active)
  );

  assign fault_irq   = pending;
  assign active_unit = active;
endmodule

// File: rtl/dlc_chk.sv
`timescale 1ns/1ps
module dlc_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4,
  localparam int BUS_W = ADDR_W + DATA_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmp_en,
  input logic [ADDR_W-1:0] u0_addr,
  input logic [DATA_W-1:0] u0_wdata,
  input logic              u0_rd_stb,
  input logic              u0_wr_stb,
  input logic [ADDR_W-1:0] u1_addr,
  input logic [DATA_W-1:0] u1_wdata,
  input logic              u1_rd_stb,
  input logic              u1_wr_stb,
  input logic              irq_ack,
  input logic              swap_req,
  input logic              fault_irq,
  input logic              active_unit,
  input logic [CNT_W-1:0]  miss_count,
  input logic [BUS_W-1:0]  cap_u0,
  input logic [BUS_W-1:0]  cap_u1
);
  logic seen_q;
  logic differ;

  assign seen_q = cmp_en & (u0_rd_stb | u0_wr_stb | u1_rd_stb | u1_wr_stb);
  assign differ = seen_q &
                  ({u0_wr_stb, u0_rd_stb, u0_addr, u0_wdata} !=
                   {u1_wr_stb, u1_rd_stb, u1_addr, u1_wdata});

  p_raise_on_diff_r3: assert property (@(posedge clk) disable iff (!rst_n)
    differ |=> fault_irq);

  p_quiet_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && !fault_irq) |=> !fault_irq);

  p_irq_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && !irq_ack && !swap_req) |=> fault_irq);

  p_count_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count == {CNT_W{1'b1}}) |=> (miss_count == {CNT_W{1'b1}}));

  p_count_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !differ |=> $stable(miss_count));

  p_cap_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && !irq_ack && !swap_req) |=> ($stable(cap_u0) && $stable(cap_u1)));

  p_swap_toggles_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_irq && swap_req && !differ) |=> ((active_unit != $past(active_unit)) && !fault_irq));

  p_swap_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault_irq && swap_req) |=> $stable(active_unit));
endmodule

bind duplex_match_chk dlc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmp_en      (cmp_en),
  .u0_addr     (u0_addr),
  .u0_wdata    (u0_wdata),
  .u0_rd_stb   (u0_rd_stb),
  .u0_wr_stb   (u0_wr_stb),
  .u1_addr     (u1_addr),
  .u1_wdata    (u1_wdata),
  .u1_rd_stb   (u1_rd_stb),
  .u1_wr_stb   (u1_wr_stb),
  .irq_ack     (irq_ack),
  .swap_req    (swap_req),
  .fault_irq   (fault_irq),
  .active_unit (active_unit),
  .miss_count  (miss_count),
  .cap_u0      (cap_u0),
  .cap_u1      (cap_u1)
);

// File: tb/duplex_match_chk_tb_top.sv
`timescale 1ns/1ps
module duplex_match_chk_tb_top;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int BUS_W  = ADDR_W + DATA_W + 2;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic              clk;
  logic              rst_n;
  logic              cmp_en;
  logic [ADDR_W-1:0] u0_addr, u1_addr;
  logic [DATA_W-1:0] u0_wdata, u1_wdata;
  logic              u0_rd_stb, u0_wr_stb, u1_rd_stb, u1_wr_stb;
  logic              irq_ack, swap_req;
  logic              fault_irq, active_unit;
  logic [CNT_W-1:0]  miss_count;
  logic [BUS_W-1:0]  cap_u0, cap_u1;

  int n_checks = 0;
  int n_fails  = 0;
  int exp_cnt  = 0;
  bit done     = 0;

  duplex_match_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_en(cmp_en),
    .u0_addr(u0_addr), .u0_wdata(u0_wdata), .u0_rd_stb(u0_rd_stb), .u0_wr_stb(u0_wr_stb),
    .u1_addr(u1_addr), .u1_wdata(u1_wdata), .u1_rd_stb(u1_rd_stb), .u1_wr_stb(u1_wr_stb),
    .irq_ack(irq_ack), .swap_req(swap_req), .fault_irq(fault_irq),
    .active_unit(active_unit), .miss_count(miss_count), .cap_u0(cap_u0), .cap_u1(cap_u1)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [BUS_W-1:0] pack(input logic wr, input logic rd,
                                            input logic [ADDR_W-1:0] a,
                                            input logic [DATA_W-1:0] d);
    return {wr, rd, a, d};
  endfunction

  task automatic drive(input logic en,
                       input logic [ADDR_W-1:0] a0, input logic [DATA_W-1:0] d0,
                       input logic r0, input logic w0,
                       input logic [ADDR_W-1:0] a1, input logic [DATA_W-1:0] d1,
                       input logic r1, input logic w1);
    cmp_en = en;
    u0_addr = a0; u0_wdata = d0; u0_rd_stb = r0; u0_wr_stb = w0;
    u1_addr = a1; u1_wdata = d1; u1_rd_stb = r1; u1_wr_stb = w1;
  endtask

  task automatic idle();
    drive(1'b1, '0, '0, 1'b0, 1'b0, '0, '0, 1'b0, 1'b0);
    irq_ack = 1'b0; swap_req = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 irq", fault_irq, 0);
    chk("R1 active", active_unit, 0);
    chk("R1 count", miss_count, 0);
    chk("R1 cap0", cap_u0, 0);
    chk("R1 cap1", cap_u1, 0);
  endtask

  task automatic t_match();
    for (int i = 0; i < 4; i++) begin
      drive(1'b1, 16'h1000 + i, 32'hA5A5_0000 + i, i[0], ~i[0],
                  16'h1000 + i, 32'hA5A5_0000 + i, i[0], ~i[0]);
      tick();
    end
    chk("R11 equal bundles no irq", fault_irq, 0);
    chk("R11 equal bundles count", miss_count, 0);
  endtask

  task automatic t_gate();
    drive(1'b0, 16'h0001, 32'h1, 1'b1, 1'b0, 16'h0002, 32'h2, 1'b1, 1'b0);
    tick();
    chk("R2 cmp_en low", fault_irq, 0);
    drive(1'b1, 16'h0001, 32'h1, 1'b0, 1'b0, 16'h0002, 32'h2, 1'b0, 1'b0);
    tick();
    chk("R2 no strobe", fault_irq, 0);
    chk("R2 count unchanged", miss_count, 0);
  endtask

  task automatic t_miss();
    drive(1'b1, 16'h2222, 32'hDEAD_BEEF, 1'b0, 1'b1, 16'h2222, 32'hDEAD_BEE0, 1'b0, 1'b1);
    tick(); exp_cnt++;
    chk("R3 data diff raises irq", fault_irq, 1);
    chk("R5 count", miss_count, exp_cnt);
    chk("R6 cap0", cap_u0, pack(1'b1, 1'b0, 16'h2222, 32'hDEAD_BEEF));
    chk("R6 cap1", cap_u1, pack(1'b1, 1'b0, 16'h2222, 32'hDEAD_BEE0));
    drive(1'b1, 16'h3333, 32'h0, 1'b1, 1'b0, 16'h3334, 32'h0, 1'b1, 1'b0);
    tick(); exp_cnt++;
    chk("R7 cap0 kept", cap_u0, pack(1'b1, 1'b0, 16'h2222, 32'hDEAD_BEEF));
    chk("R7 cap1 kept", cap_u1, pack(1'b1, 1'b0, 16'h2222, 32'hDEAD_BEE0));
    chk("R5 count while pending", miss_count, exp_cnt);
    idle(); tick(); tick();
    chk("R4 irq held", fault_irq, 1);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk("R4 ack clears", fault_irq, 0);
    chk("R9 ack keeps active", active_unit, 0);
  endtask

  task automatic t_swap_idle();
    swap_req = 1'b1; tick(); swap_req = 1'b0; tick();
    chk("R9 swap without fault", active_unit, 0);
  endtask

  task automatic t_swap();
    drive(1'b1, 16'h4444, 32'h5, 1'b1, 1'b0, 16'h4444, 32'h5, 1'b0, 1'b0);
    tick(); exp_cnt++;
    chk("R3 strobe diff raises irq", fault_irq, 1);
    idle(); swap_req = 1'b1; tick(); swap_req = 1'b0;
    chk("R8 active toggled", active_unit, 1);
    chk("R8 irq cleared", fault_irq, 0);
  endtask

  task automatic t_race();
    drive(1'b1, 16'h0A0A, 32'h1, 1'b1, 1'b0, 16'h0B0A, 32'h1, 1'b1, 1'b0);
    tick(); exp_cnt++;
    chk("R3 addr diff raises irq", fault_irq, 1);
    drive(1'b1, 16'h0C0C, 32'h77, 1'b0, 1'b1, 16'h0C0C, 32'h78, 1'b0, 1'b1);
    irq_ack = 1'b1; tick(); exp_cnt++;
    irq_ack = 1'b0;
    chk("R10 irq stays", fault_irq, 1);
    chk("R10 cap0 new", cap_u0, pack(1'b1, 1'b0, 16'h0C0C, 32'h77));
    chk("R10 cap1 new", cap_u1, pack(1'b1, 1'b0, 16'h0C0C, 32'h78));
    idle(); irq_ack = 1'b1; tick(); irq_ack = 1'b0;
    chk("R4 cleared after race", fault_irq, 0);
  endtask

  task automatic t_sat();
    for (int i = 0; i < 20; i++) begin
      drive(1'b1, 16'h5555, 32'(i), 1'b0, 1'b1, 16'h5555, 32'(i + 1), 1'b0, 1'b1);
      tick();
      if (exp_cnt < CMAX) exp_cnt++;
    end
    chk("R5 saturated count", miss_count, CMAX);
    chk("R5 model agrees", exp_cnt, CMAX);
    idle(); irq_ack = 1'b1; tick(); irq_ack = 1'b0; tick();
    chk("R5 count kept after ack", miss_count, CMAX);
    chk("R8 active still 1", active_unit, 1);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    idle();
    repeat (3) tick();
    t_reset();
    rst_n = 1'b1;
    tick();
    t_match();
    t_gate();
    t_miss();
    t_swap_idle();
    t_swap();
    t_race();
    t_sat();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule